// File: doc/BRIEF.md
# Segmentation Pointer Table Scanner

This block serves one transmit port of a cell segmentation engine. The port owns a small table of up to 32 pointer words in memory. Each word names the control structure of one virtual circuit carried by the port. When the scheduler asks for the next circuit, the scanner reads table words through a simple request/acknowledge memory read port. It starts where the previous request stopped and passes over entries that are switched off. It returns the absolute word address of the first enabled control structure it finds. After the entry flagged as the final one, or after entry 31, the walk continues at entry 0.

Each table word has three fields: a last flag, an enable flag and a 14-bit word offset. The scanner adds the offset to the fixed control-memory word base 0x40000, which is byte address 0x80000. A request is only taken when the global transmit enable is set and the port's 2-bit mode field selects structured operation. If a request finds no enabled entry in one complete lap of the table, the scanner raises a one-cycle empty indication and returns to idle instead of looping.

The FSM has four states. ST_IDLE waits for a request. ST_FETCH reads one table word. ST_EMIT presents the pointer until downstream accepts it. ST_NOPTR reports an empty lap. The transitions are:
- IDLE→FETCH: a request is accepted while the port is enabled.
- FETCH→FETCH: a disabled entry is read and the lap is not yet complete.
- FETCH→EMIT: an enabled entry is read.
- FETCH→NOPTR: a disabled entry is read and the next index equals the index the lap started from.
- EMIT→IDLE: `cs_ready` is high.
- NOPTR→IDLE: always, after one cycle.

Top module: `sptr_scan`

## Requirements
- R1: After reset, `cs_valid`, `scan_empty` and `rd_en` are 0, and the first table read of the first request is at entry 0.
- R2: A request is ignored unless `master_en` is 1 and `port_mode` is 2'b11. An ignored request causes no memory read and no output.
- R3: The read address is `tbl_base` with its low 5 bits replaced by the entry index, so the table sits on a 32-word boundary. `rd_en` and `rd_addr` hold steady until `rd_ack`, which returns `rd_data` in the same cycle.
- R4: Each table word carries the last flag in bit 15, the enable flag in bit 14 and the offset in bits 13:0. The emitted `cs_addr` equals 0x40000 plus the offset.
- R5: An entry whose enable bit is 0 is read but never emitted, and the walk goes on to the following entry within the same request.
- R6: The entry after one whose last bit is 1, or after entry 31, is entry 0. Entries beyond the last-flagged one are never read.
- R7: Each request resumes at the entry after the one emitted by the previous request, giving round-robin service.
- R8: Each request produces exactly one pointer. `cs_valid` stays high with `cs_addr` unchanged until `cs_ready` is sampled high.
- R9: If one full lap from the starting entry finds no enabled entry, `scan_empty` pulses for one cycle, `cs_valid` stays low, and the next request starts at the same entry.
- R10: A request that arrives while a scan or emission is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Global transmit enable |
| port_mode | input | 2 | Port mode; 2'b11 selects structured operation |
| tbl_base | input | 20 | Table base word address; low 5 bits ignored |
| sched_req | input | 1 | Request for the next pointer |
| rd_en | output | 1 | Table read request |
| rd_addr | output | 20 | Table word address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid |
| rd_data | input | 16 | Table word |
| cs_valid | output | 1 | Pointer valid |
| cs_addr | output | 20 | Absolute control-structure word address |
| cs_ready | input | 1 | Downstream accepts the pointer |
| scan_empty | output | 1 | One-cycle pulse: the lap found no enabled entry |

## Verification
The wrap after the last-flagged entry and the end-of-lap detection can fall on the same table read. This happens when the disabled last entry sends the index back to 0 and 0 is also where the lap began. It also happens when the lap started further in, and the wrap lands one step short of home. The bench builds tables with every entry up to the last-flagged one disabled, and starts requests from a non-zero index. It judges the result by the `scan_empty` pulse, by the absence of `cs_valid`, by the exact count of memory reads, and by the entry where the next request resumes.

// File: rtl/sptr_pkg.sv
package sptr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EMIT,
        ST_NOPTR
    } scan_state_e;

    localparam logic [1:0] MODE_STRUCTURED = 2'b11;
endpackage

// File: rtl/sptr_index.sv
module sptr_index #(
    parameter int MAX_ENTRIES = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           mark_start,
    input  logic                           step,
    input  logic                           last_seen,
    output logic [$clog2(MAX_ENTRIES)-1:0] idx,
    output logic                           back_home
);
    localparam int IDX_W = $clog2(MAX_ENTRIES);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_ENTRIES - 1);

    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] nxt;

    // wrap after a last-flagged entry or at the end of the table
    assign nxt       = (last_seen || idx == TOP_IDX) ? '0 : idx + 1'b1;
    assign back_home = (nxt == start_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            start_q <= '0;
        end else begin
            if (mark_start) start_q <= idx;
            if (step)       idx     <= nxt;
        end
    end
endmodule

// File: rtl/sptr_entry_decode.sv
module sptr_entry_decode #(
    parameter int          AW      = 20,
    parameter int          OFF_W   = 14,
    parameter logic [19:0] CM_BASE = 20'h40000
) (
    input  logic [OFF_W+1:0] word,
    output logic             last_flag,
    output logic             en_flag,
    output logic [AW-1:0]    abs_addr
);
    assign last_flag = word[OFF_W+1];
    assign en_flag   = word[OFF_W];
    assign abs_addr  = AW'(CM_BASE) + AW'(word[OFF_W-1:0]);
endmodule

// File: rtl/sptr_scan.sv
module sptr_scan
    import sptr_pkg::*;
#(
    parameter int          AW          = 20,
    parameter int          MAX_ENTRIES = 32,
    parameter int          OFF_W       = 14,
    parameter logic [19:0] CM_BASE     = 20'h40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [1:0]       port_mode,
    input  logic [AW-1:0]    tbl_base,
    input  logic             sched_req,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic             rd_ack,
    input  logic [OFF_W+1:0] rd_data,
    output logic             cs_valid,
    output logic [AW-1:0]    cs_addr,
    input  logic             cs_ready,
    output logic             scan_empty
);
    localparam int IDX_W = $clog2(MAX_ENTRIES);

    scan_state_e      state_q, state_nx;
    logic [IDX_W-1:0] idx;
    logic             back_home;
    logic             ent_last, ent_en;
    logic [AW-1:0]    ent_abs;
    logic [AW-1:0]    addr_q;
    logic             port_ok, start_go, word_in;

    assign port_ok  = master_en && (port_mode == MODE_STRUCTURED);
    assign start_go = (state_q == ST_IDLE) && sched_req && port_ok;
    assign word_in  = (state_q == ST_FETCH) && rd_ack;

    sptr_index #(.MAX_ENTRIES(MAX_ENTRIES)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_start (start_go),
        .step       (word_in),
        .last_seen  (ent_last),
        .idx        (idx),
        .back_home  (back_home)
    );

    sptr_entry_decode #(.AW(AW), .OFF_W(OFF_W), .CM_BASE(CM_BASE)) u_decode (
        .word      (rd_data),
        .last_flag (ent_last),
        .en_flag   (ent_en),
        .abs_addr  (ent_abs)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_go) state_nx = ST_FETCH;
            ST_FETCH: if (rd_ack) begin
                          if (ent_en)         state_nx = ST_EMIT;
                          else if (back_home) state_nx = ST_NOPTR;
                      end
            ST_EMIT:  if (cs_ready) state_nx = ST_IDLE;
            ST_NOPTR: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // captured pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                addr_q <= '0;
        else if (word_in && ent_en) addr_q <= ent_abs;
    end

    // outputs
    always_comb begin
        rd_en      = 1'b0;
        cs_valid   = 1'b0;
        scan_empty = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: rd_en      = 1'b1;
            ST_EMIT:  cs_valid   = 1'b1;
            ST_NOPTR: scan_empty = 1'b1;
            default:  ;
        endcase
    end

    assign rd_addr = {tbl_base[AW-1:IDX_W], idx};
    assign cs_addr = addr_q;
endmodule

// File: rtl/sptr_scan_chk.sv
module sptr_scan_chk #(
    parameter int          AW      = 20,
    parameter logic [19:0] CM_BASE = 20'h40000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_en,
    input logic [1:0]    port_mode,
    input logic [AW-1:0] tbl_base,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          cs_valid,
    input logic [AW-1:0] cs_addr,
    input logic          cs_ready,
    input logic          scan_empty
);
    AST_RD_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(master_en && port_mode == 2'b11)); // R2

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_addr[AW-1:5] == tbl_base[AW-1:5]); // R3

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ack) |=> (rd_en && $stable(rd_addr))); // R3

    AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_valid |-> (cs_addr >= AW'(CM_BASE) && cs_addr < AW'(CM_BASE) + AW'(20'h4000))); // R4

    AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && !cs_ready) |=> (cs_valid && $stable(cs_addr))); // R8

    AST_ONE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && cs_ready) |=> !cs_valid); // R8

    AST_EMPTY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_empty |=> !scan_empty); // R9

    AST_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_empty && (cs_valid || rd_en))); // R9
endmodule

bind sptr_scan sptr_scan_chk #(.AW(AW), .CM_BASE(CM_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .port_mode  (port_mode),
    .tbl_base   (tbl_base),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .cs_valid   (cs_valid),
    .cs_addr    (cs_addr),
    .cs_ready   (cs_ready),
    .scan_empty (scan_empty)
);

// File: tb/tb_sptr_scan.sv
`timescale 1ns/1ps
module tb_sptr_scan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic [1:0]  port_mode = 2'b00;
    logic [19:0] tbl_base = 20'h01A53;
    logic        sched_req = 1'b0;
    logic        rd_en;
    logic [19:0] rd_addr;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic        cs_valid;
    logic [19:0] cs_addr;
    logic        cs_ready = 1'b0;
    logic        scan_empty;

    logic [15:0] tmem [32];
    int          reads = 0;
    logic        addr_bad = 1'b0;
    logic [4:0]  last_rd_idx = '0;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    sptr_scan dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .port_mode(port_mode),
        .tbl_base(tbl_base), .sched_req(sched_req), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .cs_valid(cs_valid), .cs_addr(cs_addr),
        .cs_ready(cs_ready), .scan_empty(scan_empty)
    );

    // table memory: acknowledges one cycle after each request
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            rd_data <= '0;
        end else if (rd_en && !rd_ack) begin
            rd_ack      <= 1'b1;
            rd_data     <= tmem[rd_addr[4:0]];
            last_rd_idx <= rd_addr[4:0];
            reads       <= reads + 1;
            if (rd_addr[19:5] != 15'h00D2) addr_bad <= 1'b1;
        end else begin
            rd_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_req();
        @(negedge clk) sched_req = 1'b1;
        @(negedge clk) sched_req = 1'b0;
    endtask

    // wait for either outcome; hold back ready for 'hold' cycles
    task automatic expect_result(input string tag, input logic exp_empty,
                                 input logic [19:0] exp_addr, input int hold);
        bit seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cs_valid || scan_empty) begin seen = 1; break; end
        end
        check({tag, " outcome seen"}, seen, 32'(seen), 1);
        if (!seen) return;
        check({tag, " kind"}, scan_empty == exp_empty && cs_valid == !exp_empty,
              32'(scan_empty), 32'(exp_empty));
        if (!exp_empty) begin
            check({tag, " address"}, cs_addr == exp_addr, 32'(cs_addr), 32'(exp_addr));
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check("R8 held until ready", cs_valid && cs_addr == exp_addr, 32'(cs_addr), 32'(exp_addr));
            end
            cs_ready = 1'b1;
            @(negedge clk) cs_ready = 1'b0;
            check("R8 released after ready", !cs_valid, 32'(cs_valid), 0);
        end else begin
            @(negedge clk);
            check("R9 empty lasts one cycle", !scan_empty && !cs_valid, 32'(scan_empty), 0);
        end
    endtask

    task automatic t_reset();
        check("R1 cs_valid after reset", !cs_valid, 32'(cs_valid), 0);
        check("R1 scan_empty after reset", !scan_empty, 32'(scan_empty), 0);
        check("R1 rd_en after reset", !rd_en, 32'(rd_en), 0);
    endtask

    task automatic t_gate();
        int r0 = reads;
        master_en = 1'b0; port_mode = 2'b11;
        send_req();
        repeat (10) @(negedge clk);
        master_en = 1'b1; port_mode = 2'b10;
        send_req();
        repeat (10) @(negedge clk);
        check("R2 gated requests make no reads", reads == r0, 32'(reads - r0), 0);
        check("R2 gated requests make no output", !cs_valid && !scan_empty, 32'(cs_valid), 0);
        port_mode = 2'b11;
    endtask

    task automatic t_walk();
        int r0;
        for (int k = 0; k < 32; k++) tmem[k] = 16'h4ABC;
        tmem[0] = 16'h4010; tmem[1] = 16'h0222; tmem[2] = 16'h7FFF;
        tmem[3] = 16'hC123; tmem[4] = 16'h4777;
        send_req();
        expect_result("R4 R1 first entry", 1'b0, 20'h40010, 5);
        check("R1 first read at entry 0", last_rd_idx == 5'd0, 32'(last_rd_idx), 0);
        r0 = reads;
        send_req();
        expect_result("R5 R7 skip disabled", 1'b0, 20'h43FFF, 0);
        check("R5 disabled entry was read", reads - r0 == 2, 32'(reads - r0), 2);
        send_req();
        expect_result("R4 last-flagged entry", 1'b0, 20'h40123, 2);
        r0 = reads;
        send_req();
        @(negedge clk) sched_req = 1'b1;   // arrives while busy
        @(negedge clk) sched_req = 1'b0;
        expect_result("R6 wrap after last", 1'b0, 20'h40010, 0);
        check("R6 entry 4 never read", reads - r0 == 1, 32'(reads - r0), 1);
        r0 = reads;
        repeat (12) @(negedge clk);
        check("R10 busy request ignored", reads == r0 && !cs_valid, 32'(reads - r0), 0);
    endtask

    task automatic t_empty();
        int r0;
        for (int k = 0; k < 32; k++) tmem[k] = 16'h4888;
        tmem[0] = 16'h0000; tmem[1] = 16'h0005; tmem[2] = 16'h8006;
        for (int pass = 0; pass < 2; pass++) begin
            r0 = reads;
            send_req();
            expect_result("R9 empty lap", 1'b1, 20'h0, 0);
            check("R9 lap read count", reads - r0 == 3, 32'(reads - r0), 3);
            check("R9 lap ended at entry 0", last_rd_idx == 5'd0, 32'(last_rd_idx), 0);
        end
    endtask

    task automatic t_top_wrap();
        int r0;
        for (int k = 0; k < 32; k++) tmem[k] = 16'h0000;
        tmem[31] = 16'h4031; tmem[0] = 16'h4000;
        r0 = reads;
        send_req();
        expect_result("R7 resume at entry 1", 1'b0, 20'h40031, 0);
        check("R7 reads 1..31", reads - r0 == 31, 32'(reads - r0), 31);
        r0 = reads;
        send_req();
        expect_result("R6 wrap after entry 31", 1'b0, 20'h40000, 0);
        check("R6 single read", reads - r0 == 1, 32'(reads - r0), 1);
        check("R3 read address alignment", !addr_bad, 32'(addr_bad), 0);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) tmem[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_walk();
        t_empty();
        t_top_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule